// File: doc/BRIEF.md
# Quarter-Period Delay-and-Average Filter for Rotating-Frame Voltage

This block cleans up the d-axis and q-axis voltage words that a rotating-frame transform of three-phase mains produces. For each axis it adds the current sample to the sample taken a quarter of a fundamental period earlier, then halves the sum. In the rotating frame, mains unbalance shows up as ripple at twice the line frequency. The 5th and 7th phase harmonics show up as ripple at six times the line frequency. A quarter-period shift turns both of these ripples into their own negation, so the add cancels them and leaves the DC positive-sequence fundamental.

The quarter period is given in samples on a run-time input. A frequency estimator outside the block can therefore retune it as the mains drifts by about ±1.5%. Each axis keeps a circular history of up to `DEPTH` samples. The two axes share one input beat, so their results stay aligned in time.

Samples enter and results leave through a valid/ready stream pair that carries both axes together. The input is ready whenever the output register is empty or being drained in the same cycle. While the output is stalled (`out_valid` high and `out_ready` low), the input is not ready and the output words hold still. A result appears one cycle after the sample that produced it is accepted.

Top module: `qdf_quarter_avg`

## Requirements
- R1: For each axis, an output equals the floor of (x[n] + x[n-D]) / 2, where x[n] is the accepted sample and x[n-D] is the sample accepted D beats earlier. The sum is formed one bit wider and shifted right arithmetically, so inputs at the extremes of the signed range never overflow.
- R2: A constant input C on an axis produces the output C once the history is primed.
- R3: When D is one quarter of the fundamental period, ripple with a period of 2D samples (twice the fundamental) and ripple with a period of 2D/3 samples (six times the fundamental) cancel completely. Only the DC level remains at the output.
- R4: After reset no result is valid until at least D samples have been accepted. A sample produces a valid result only if at least D samples were accepted before it.
- R5: The delay D is taken from `delay_len` at the beat on which each sample is accepted, so a change applies from the next accepted sample. A value of 0 acts as 1, and a value above `DEPTH` acts as `DEPTH`.
- R6: The d and q axes use separate histories but share the same beat. The two results of one sample appear together in the same output beat.
- R7: `in_ready` equals NOT `out_valid` OR `out_ready`. While the output is stalled, `out_d`, `out_q` and `out_valid` hold, and any input presented is ignored. A result appears in the cycle after its sample is accepted. With no accepted sample and `out_ready` high, `out_valid` falls.
- R8: During and just after reset, `out_valid` is 0, `in_ready` is 1 and both output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| delay_len | input | $clog2(DEPTH)+1 | Quarter-period delay in samples |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken |
| in_d | input | W | Signed d-axis sample |
| in_q | input | W | Signed q-axis sample |
| out_valid | output | 1 | Filtered pair available |
| out_ready | input | 1 | Downstream takes the filtered pair |
| out_d | output | W | Filtered d-axis word |
| out_q | output | W | Filtered q-axis word |

## Verification
- **Write pointer or read offset wrong:** a wrong delayed sample is paired with the current one. This shows as a mismatch on the first primed output after the fault, one cycle after that sample is accepted.
- **Fill count wrong:** `out_valid` rises one or more beats too early or too late after reset or after a delay increase. The error is visible on the very beat where priming should change.
- **Handshake error:** a stall slip shows within a single cycle, either as a moving output word or as a lost or duplicated sample. A lost or duplicated sample corrupts every later comparison against the bench's own history.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

  // number of rotating-frame axes carried side by side
  localparam int QDF_AXES = 2;

  // Effective delay: zero is promoted to one, large requests are capped.
  function automatic int unsigned qdf_clamp(input int unsigned req,
                                            input int unsigned depth);
    if (req == 0) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

endpackage

// File: rtl/qdf_ring.sv
// Per-axis circular history: write at the head, read an older slot.
module qdf_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_ptr,
  input  logic [AW-1:0]       rd_ptr,
  input  logic signed [W-1:0] wr_data,
  output logic signed [W-1:0] rd_data
);

  logic signed [W-1:0] slots [DEPTH];

  // read sees the old content, even when rd_ptr == wr_ptr (delay of DEPTH)
  assign rd_data = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= wr_data;
  end

endmodule

// File: rtl/qdf_avg.sv
// Halved sum of two signed words without overflow.
module qdf_avg #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] now_s,
  input  logic signed [W-1:0] old_s,
  output logic signed [W-1:0] mean_s
);

  logic signed [W:0] wide_sum;

  always_comb begin
    wide_sum = {now_s[W-1], now_s} + {old_s[W-1], old_s};
    mean_s   = wide_sum[W:1];   // arithmetic shift right by one
  end

endmodule

// File: rtl/qdf_ctrl.sv
// Head pointer, delayed read pointer and fill tracking shared by all axes.
module qdf_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int DLW  = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [DLW-1:0] delay_req,
  output logic [AW-1:0]  head,
  output logic [AW-1:0]  tail,
  output logic           primed
);

  logic [DLW-1:0] eff_dly;
  logic [DLW-1:0] fill;

  always_comb begin
    eff_dly = DLW'(qdf_pkg::qdf_clamp(int'(delay_req), DEPTH));
    tail    = head - eff_dly[AW-1:0];   // DEPTH wraps to head itself
    primed  = (fill >= eff_dly);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      fill <= '0;
    end else if (take) begin
      head <= head + 1'b1;
      if (fill < DLW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

endmodule

// File: rtl/qdf_quarter_avg.sv
// Quarter-period delay-and-average filter on a d/q stream.
module qdf_quarter_avg #(
  parameter int W      = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int DLW   = AW + 1,
  localparam int NAX   = qdf_pkg::QDF_AXES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DLW-1:0]      delay_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_d,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_d,
  output logic signed [W-1:0] out_q
);

  logic                take;
  logic [AW-1:0]       head;
  logic [AW-1:0]       tail;
  logic                primed;
  logic                vld_r;
  logic signed [W-1:0] ax_in   [NAX];
  logic signed [W-1:0] ax_old  [NAX];
  logic signed [W-1:0] ax_mean [NAX];
  logic signed [W-1:0] ax_out  [NAX];

  assign in_ready = !vld_r || out_ready;
  assign take     = in_valid && in_ready;
  assign ax_in[0] = in_d;
  assign ax_in[1] = in_q;

  qdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .delay_req (delay_len),
    .head      (head),
    .tail      (tail),
    .primed    (primed)
  );

  for (genvar ax = 0; ax < NAX; ax++) begin : g_axis
    qdf_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .wr_en   (take),
      .wr_ptr  (head),
      .rd_ptr  (tail),
      .wr_data (ax_in[ax]),
      .rd_data (ax_old[ax])
    );

    qdf_avg #(.W(W)) u_avg (
      .now_s  (ax_in[ax]),
      .old_s  (ax_old[ax]),
      .mean_s (ax_mean[ax])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)    ax_out[ax] <= '0;
      else if (take) ax_out[ax] <= ax_mean[ax];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         vld_r <= 1'b0;
    else if (take)      vld_r <= primed;
    else if (out_ready) vld_r <= 1'b0;
  end

  assign out_valid = vld_r;
  assign out_d     = ax_out[0];
  assign out_q     = ax_out[1];

endmodule

// File: rtl/qdf_quarter_avg_chk.sv
module qdf_quarter_avg_chk #(
  parameter int W      = 16,
  parameter int DEPTH  = 256,
  localparam int DLW   = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DLW-1:0]      delay_len,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] out_d,
  input logic signed [W-1:0] out_q
);

  logic [DLW-1:0] seen;
  logic           gate_ok;
  logic           acc;
  logic [DLW-1:0] want;

  assign acc  = in_valid && in_ready;
  assign want = DLW'(qdf_pkg::qdf_clamp(int'(delay_len), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= '0;
      gate_ok <= 1'b0;
    end else if (acc) begin
      gate_ok <= (seen >= want);
      if (seen < DLW'(DEPTH)) seen <= seen + 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_d) && $stable(out_q)); // R7
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_VALID_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R7
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && out_ready |=> !out_valid); // R7
  AST_PRIME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gate_ok); // R4

endmodule

bind qdf_quarter_avg qdf_quarter_avg_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .delay_len (delay_len),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_d     (out_d),
  .out_q     (out_q)
);

// File: tb/qdf_quarter_avg_test.sv
`timescale 1ns/1ps
module qdf_quarter_avg_test;

  localparam int W     = 8;
  localparam int DEPTH = 16;
  localparam int DLW   = $clog2(DEPTH) + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [DLW-1:0]      delay_len = '0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic signed [W-1:0] in_d = '0;
  logic signed [W-1:0] in_q = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic signed [W-1:0] out_d;
  logic signed [W-1:0] out_q;

  int checks = 0;
  int fails  = 0;
  int hd [4096];
  int hq [4096];
  int n = 0;
  int unsigned seed = 32'h1234_5678;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qdf_quarter_avg #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .delay_len(delay_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_d(in_d), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_d(out_d), .out_q(out_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 16) % 256) - 128;
  endfunction

  function automatic int eff(input int dl);
    if (dl == 0) return 1;
    if (dl > DEPTH) return DEPTH;
    return dl;
  endfunction

  // Offer one sample, wait for acceptance, then check the result one cycle later.
  task automatic push(input int d, input int q, input int dl, input string req);
    int e;
    bit pr;
    int xd;
    int xq;
    @(negedge clk);
    delay_len = DLW'(dl);
    in_d = W'(d);
    in_q = W'(q);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e  = eff(dl);
    pr = (n >= e);
    xd = pr ? ((d + hd[n-e]) >>> 1) : 0;
    xq = pr ? ((q + hq[n-e]) >>> 1) : 0;
    hd[n] = d;
    hq[n] = q;
    n++;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == pr, {req, " R4 valid"}, int'(out_valid), int'(pr));
    if (pr) begin
      chk(int'(out_d) == xd, {req, " R1 d"}, int'(out_d), xd);
      chk(int'(out_q) == xq, {req, " R6 q"}, int'(out_q), xq);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int sd;
    int dc_d;
    int dc_q;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    chk(out_d == 0 && out_q == 0, "R8 data", int'(out_d), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 after release", int'(out_valid), 0);

    // R4 priming with delay 5
    for (int i = 0; i < 12; i++) push(i * 3 - 10, 7 - i, 5, "R4 prime");

    // R1 sweep over all legal delays, including signed extremes
    for (int dl = 1; dl <= DEPTH; dl++) begin
      for (int i = 0; i < 40; i++) begin
        if (i % 9 == 0)      push(127, -128, dl, "R1 extremes");
        else if (i % 9 == 1) push(127, -128, dl, "R1 extremes");
        else                 push(rnd8(), rnd8(), dl, "R1 sweep");
      end
    end

    // R5 clamping and delay change on the next sample
    for (int i = 0; i < 20; i++) push(rnd8(), rnd8(), 0, "R5 zero");
    for (int i = 0; i < 20; i++) push(rnd8(), rnd8(), 31, "R5 cap");
    for (int i = 0; i < 20; i++) push(rnd8(), rnd8(), (i % 2) ? 3 : 11, "R5 toggle");

    // R2 DC passes through unchanged
    dc_d = -77;
    dc_q = 50;
    for (int i = 0; i < 30; i++) begin
      push(dc_d, dc_q, 12, "R2 dc");
      if (i >= 12) begin
        chk(int'(out_d) == dc_d, "R2 dc d", int'(out_d), dc_d);
        chk(int'(out_q) == dc_q, "R2 dc q", int'(out_q), dc_q);
      end
    end

    // R3 second and sixth ripple cancel with D = 12 (periods 24 and 8)
    for (int i = 0; i < 72; i++) begin
      int s2;
      int s6;
      s2 = ((i % 24) < 12) ? 40 : -40;
      s6 = ((i % 8) < 4) ? 30 : -30;
      push(20 + s2 + s6, -15 - s2 + s6, 12, "R3 ripple");
      if (i >= 12) begin
        chk(int'(out_d) == 20, "R3 d ripple cancel", int'(out_d), 20);
        chk(int'(out_q) == -15, "R6 R3 q ripple cancel", int'(out_q), -15);
      end
    end

    // R7 stall: output holds, input ignored, then resumes
    push(33, -44, 4, "R7 pre");
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle drain", int'(out_valid), 0);
    push(61, 9, 4, "R7 load");
    out_ready = 1'b0;
    sd = int'(out_d);
    in_valid = 1'b1;
    in_d = 8'sd99;
    in_q = -8'sd99;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R7 stall valid", int'(out_valid), 1);
      chk(int'(out_d) == sd, "R7 stall hold", int'(out_d), sd);
      chk(in_ready == 1'b0, "R7 backpressure", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) push(rnd8(), rnd8(), 4, "R7 resume");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule